// File: doc/BRIEF.md
# Interrupt Vector and Status Logic

This block collects the event flags of a serial-bus controller into a sticky status register and turns them into one interrupt line and two DMA request lines (receive and transmit). Events arrive from the transfer engine as single-cycle set pulses on a status-wide vector. Software selects which of the five low-order events may interrupt through an enable mask. It services them by reading a vector register. Each vector read names the highest-priority pending enabled event and acknowledges it.

Software reaches four registers through a small register port. Each access gives a 2-bit select code, a read or write strobe and 16-bit write data. Read data is combinational from the select code. Side effects of a read, such as the vector acknowledge, take hold at the clock edge that ends the read cycle. Reset is synchronous and active high.

Top module: `irq_vector_status`

## Requirements
- R1: `irq` is high exactly when at least one of status bits 4..0 is set while the same bit of the enable mask is set.
- R2: A write with select code 0 loads the enable mask from write-data bits 4..0 and drops all higher bits. A read with code 0 returns the mask zero-extended.
- R3: A read with select code 2 returns one plus the index of the lowest-numbered bit that is both pending and enabled, or 0 if there is none. At the end of that read cycle, only that one status bit is cleared.
- R4: A write with select code 3 stores only write-data bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). A read with code 3 returns them at those positions, with all other bits 0.
- R5: A code-3 write with bit 15 set clears mask bit 3. A code-3 write with bit 7 set clears mask bit 4.
- R6: `rx_req` equals status bit 3 while receive DMA is enabled and is 0 otherwise. `tx_req` equals status bit 4 while transmit DMA is enabled and is 0 otherwise.
- R7: A read with select code 1 returns the status register with bit 12 replaced by `bus_busy`. Status bit 12 is never stored, so an event pulse on bit 12 leaves no trace.
- R8: Writes with select code 1 (status) or code 2 (vector) change no state.
- R9: Status bits are sticky: an event pulse sets its bit and the bit stays set until a vector read clears it. If an event and a vector-read clear hit the same bit in the same cycle, the bit stays set.
- R10: Synchronous reset clears the status, the mask and both DMA enables, and drives `irq`, `rx_req` and `tx_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_set | input | 16 | Event set pulses, one per status bit |
| bus_busy | input | 1 | Live bus-busy level, shown in status reads |
| reg_addr | input | 2 | Register select: 0 mask, 1 status, 2 vector, 3 DMA control |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; only matters for the vector acknowledge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| rx_req | output | 1 | Receive DMA request |
| tx_req | output | 1 | Transmit DMA request |

## Verification
A corrupted status bit shows up on `irq` or on a DMA request in the cycle after it goes wrong, provided that bit is enabled. Otherwise it shows up at the next status read. A wrong priority pick or a clear of the wrong bit appears in the value returned by the vector read itself. It also appears in the status read that follows one cycle later. A lost mask update from a DMA-control write appears in the very next mask read. The bench therefore pairs every vector read with a status read in the following cycle.

// File: rtl/irq_vector_status.sv
module irq_vector_status #(
  parameter int STAT_W    = 16,
  parameter int MASK_W    = 5,
  parameter int RXR_BIT   = 3,
  parameter int TXR_BIT   = 4,
  parameter int BUSY_BIT  = 12,
  parameter int RXDMA_BIT = 15,
  parameter int TXDMA_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt_set,
  input  logic              bus_busy,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              irq,
  output logic              rx_req,
  output logic              tx_req
);
  localparam int VW = $clog2(MASK_W + 1);
  localparam logic [1:0] A_MASK = 2'd0, A_STAT = 2'd1, A_VEC = 2'd2, A_DMA = 2'd3;
  localparam logic [STAT_W-1:0] KEEP = ~(STAT_W'(1) << BUSY_BIT);

  logic [STAT_W-1:0] stat, stat_clr;
  logic [MASK_W-1:0] mask, pend, clr;
  logic [VW-1:0]     vec;
  logic              dma_rx, dma_tx, rd_vec;

  assign pend   = stat[MASK_W-1:0] & mask;
  assign rd_vec = reg_rd && reg_addr == A_VEC;

  always_comb begin
    vec = '0;
    clr = '0;
    for (int i = MASK_W - 1; i >= 0; i--)
      if (pend[i]) begin
        vec    = VW'(i + 1);
        clr    = '0;
        clr[i] = 1'b1;
      end
  end

  assign stat_clr = rd_vec ? STAT_W'(clr) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat   <= '0;
      mask   <= '0;
      dma_rx <= 1'b0;
      dma_tx <= 1'b0;
    end else begin
      stat <= ((stat & ~stat_clr) | evt_set) & KEEP;
      if (reg_wr) begin
        case (reg_addr)
          A_MASK: mask <= reg_wdata[MASK_W-1:0];
          A_DMA: begin
            dma_rx <= reg_wdata[RXDMA_BIT];
            dma_tx <= reg_wdata[TXDMA_BIT];
            if (reg_wdata[RXDMA_BIT]) mask[RXR_BIT] <= 1'b0;
            if (reg_wdata[TXDMA_BIT]) mask[TXR_BIT] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MASK: reg_rdata = STAT_W'(mask);
      A_STAT: reg_rdata = stat | (STAT_W'(bus_busy) << BUSY_BIT);
      A_VEC:  reg_rdata = STAT_W'(vec);
      default: begin
        reg_rdata[RXDMA_BIT] = dma_rx;
        reg_rdata[TXDMA_BIT] = dma_tx;
      end
    endcase
  end

  assign irq    = |pend;
  assign rx_req = dma_rx & stat[RXR_BIT];
  assign tx_req = dma_tx & stat[TXR_BIT];

  a_r1_irq_has_vector: assert property (@(posedge clk) disable iff (rst)
    irq == (vec != '0));
  a_r3_clears_one: assert property (@(posedge clk) disable iff (rst)
    (rd_vec && irq) |=> ((stat & $past(stat_clr & ~evt_set)) == '0));
  a_r5_rx_dma_mask: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_DMA && reg_wdata[RXDMA_BIT]) |=> (!mask[RXR_BIT] && dma_rx));
  a_r5_tx_dma_mask: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_DMA && reg_wdata[TXDMA_BIT]) |=> (!mask[TXR_BIT] && dma_tx));
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd_vec |=> ((stat & $past(stat)) == $past(stat)));
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (stat == '0 && mask == '0 && !irq && !rx_req && !tx_req));
endmodule

// File: tb/tb_irq_vector_status.sv
module tb_irq_vector_status;
  logic clk = 1'b0, rst = 1'b1, bus_busy = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] evt_set = '0, reg_wdata = '0, reg_rdata, v;
  logic [1:0]  reg_addr = '0;
  logic irq, rx_req, tx_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_status dut (.clk, .rst, .evt_set, .bus_busy, .reg_addr, .reg_wr,
    .reg_rd, .reg_wdata, .reg_rdata, .irq, .rx_req, .tx_req);

  // {events, mask, expected vector}
  localparam logic [36:0] TBL [6] = '{
    {16'h0006, 5'h1F, 16'd2}, {16'h0010, 5'h1F, 16'd5}, {16'h0006, 5'h04, 16'd3},
    {16'h0018, 5'h00, 16'd0}, {16'h0001, 5'h01, 16'd1}, {16'h00E0, 5'h1F, 16'd0}};

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk) begin reg_addr = a; reg_wdata = d; reg_wr = 1'b1; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk) begin reg_addr = a; reg_rd = 1'b1; end
    #1 d = reg_rdata;
    @(negedge clk) reg_rd = 1'b0;
  endtask

  task automatic pulse(logic [15:0] e);
    @(negedge clk) evt_set = e;
    @(negedge clk) evt_set = '0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R10 irq", 16'(irq), 0); chk("R10 rx_req", 16'(rx_req), 0); chk("R10 tx_req", 16'(tx_req), 0);
    rd(2'd1, v); chk("R10 status", v, 0);
    rd(2'd0, v); chk("R10 mask", v, 0);
    rd(2'd3, v); chk("R10 dma", v, 0);

    for (int i = 0; i < 6; i++) begin
      logic [15:0] e, x, s;
      e = TBL[i][36:21]; x = TBL[i][15:0];
      do_reset();
      wr(2'd0, 16'(TBL[i][20:16]));
      pulse(e);
      #1 chk("R1 irq table", 16'(irq), 16'(x != 0));
      rd(2'd2, v); chk("R3 vector table", v, x);
      s = (x != 0) ? (e & ~(16'd1 << (x - 1))) : e;
      rd(2'd1, v); chk("R3 status after vector", v, s);
    end

    do_reset();
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R2 mask width", v, 16'h001F);
    wr(2'd3, 16'hFFFF); rd(2'd3, v); chk("R4 dma bits", v, 16'h8080);
    rd(2'd0, v); chk("R5 both ready enables cleared", v, 16'h0007);
    wr(2'd0, 16'h001F); wr(2'd3, 16'h8000); rd(2'd0, v); chk("R5 rx clears bit3", v, 16'h0017);
    wr(2'd0, 16'h001F); wr(2'd3, 16'h0080); rd(2'd0, v); chk("R5 tx clears bit4", v, 16'h000F);
    rd(2'd3, v); chk("R4 dma readback", v, 16'h0080);

    do_reset();
    wr(2'd3, 16'h8080);
    pulse(16'h0008);
    #1 chk("R6 rx_req on", 16'(rx_req), 1); chk("R6 tx_req off", 16'(tx_req), 0);
    pulse(16'h0010);
    #1 chk("R6 tx_req on", 16'(tx_req), 1);
    wr(2'd3, 16'h0000);
    #1 chk("R6 rx_req gated", 16'(rx_req), 0); chk("R6 tx_req gated", 16'(tx_req), 0);
    rd(2'd1, v); chk("R6 status kept", v, 16'h0018);

    bus_busy = 1'b1;
    rd(2'd1, v); chk("R7 busy shown", v, 16'h1018);
    bus_busy = 1'b0;
    pulse(16'h1000);
    rd(2'd1, v); chk("R7 busy not stored", v, 16'h0018);

    wr(2'd0, 16'h0003);
    wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFFF);
    rd(2'd1, v); chk("R8 status write ignored", v, 16'h0018);
    rd(2'd0, v); chk("R8 mask untouched", v, 16'h0003);
    #1 chk("R1 irq masked off", 16'(irq), 0);

    wr(2'd0, 16'h001F);
    #1 chk("R1 irq enabled", 16'(irq), 1);
    @(negedge clk) begin reg_addr = 2'd2; reg_rd = 1'b1; evt_set = 16'h0008; end
    #1 v = reg_rdata;
    @(negedge clk) begin reg_rd = 1'b0; evt_set = '0; end
    chk("R9 vector with event", v, 16'd4);
    rd(2'd1, v); chk("R9 set beats clear", v, 16'h0018);
    rd(2'd2, v); chk("R3 second vector", v, 16'd4);
    rd(2'd1, v); chk("R3 cleared bit3 only", v, 16'h0010);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule